// File: doc/BRIEF.md
# Chip-Select External Bus Controller

This block connects an internal memory port, which carries one request at a time, to an external asynchronous static-memory bus for SRAM, ROM or Flash. Each request carries a 24-bit byte address. The block compares the address against four chip-select windows. Each window is placed and sized in steps of 64 KB and has its own data width (8 or 16 bits) and its own count of wait cycles. The winning window's chip-select line is driven low for the whole access. The read or write strobe is pulsed inside it, with byte-enables and data placed on the correct lanes. The request is acknowledged when the access has finished.

An access with no waits lasts two clocks. In the first clock only chip-select is active. In the second clock the strobe is active as well. Programmed waits stretch the strobe phase. After the waits, the external ready line is sampled in each final strobe clock, and the strobe is held for as long as ready is low. A 16-bit request to an 8-bit window becomes two byte cycles under one chip-select, low byte first. An address that matches no window is acknowledged with an error flag and drives no chip-select. Windows are loaded through a one-word-per-window register write port.

The sequencer has five states:
- IDLE: waits for a request.
- SETUP: chip-select only.
- WAIT: programmed waits, strobe active.
- LAST: final strobe clock, ready sampled.
- DONE: acknowledge.

It has seven transitions:
- IDLE→SETUP: request hits a window.
- IDLE→DONE: request hits no window.
- SETUP→WAIT: wait count is non-zero.
- SETUP→LAST: wait count is zero.
- WAIT→LAST: last programmed wait.
- LAST→SETUP: ready high at the end of the first byte of a split access.
- LAST→DONE: ready high at the end of the access.

Top module: `ebc_top`

## Requirements
- R1: After reset all chip-selects and both strobes are high (inactive) and the acknowledge is low. Every window is disabled, so any request ends in an error response.
- R2: Window i matches when its enable bit is set and ((addr[23:16] XOR base_i) AND mask_i) is zero. When several windows match, the lowest index wins, and only its chip-select line (ext_cs_n[i]) goes low.
- R3: A request matching no window is acknowledged with req_err high. The acknowledge comes in the clock after the request is taken, and no chip-select goes low.
- R4: With zero waits, chip-select is low for exactly 2 clocks. The strobes stay high in the first clock and the read strobe (reads) or write strobe (writes) is low in the second.
- R5: With W programmed waits, chip-select is low for 2+W clocks and the strobe is low for the last 1+W of them.
- R6: Ready is ignored during the programmed waits. After them, each clock in which ready is sampled low adds one clock with chip-select and strobe held.
- R7: In a 16-bit window a 16-bit access drives ext_be_n = 00 with the whole word. A byte access at an even address drives ext_be_n = 10 (low lane), and at an odd address ext_be_n = 01 (high lane). Read bytes are returned in req_rdata[7:0].
- R8: In an 8-bit window all data uses the low lane with ext_be_n = 10. A 16-bit access runs two byte cycles, first at the even address with the low byte, then at the odd address with the high byte. Chip-select stays low across both cycles, and the access is acknowledged once, after the second.
- R9: The read and write strobes are never low together. While the write strobe stays low, ext_dout is stable and ext_doe is high.
- R10: At most one chip-select is low at a time, and a strobe is low only while a chip-select is low.
- R11: req_ack is a single-clock pulse, and all chip-selects are high while it is asserted.
- R12: cfg_we writes cfg_wdata into window cfg_sel with these fields: base in bits 7:0, mask in bits 15:8, 16-bit width in bit 16 (1 = 16-bit), wait count in bits 20:17, enable in bit 21. The next request is decoded with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Window index for the write |
| cfg_wdata | input | 22 | Window word: enable, waits, width, mask, base |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size16 | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | Access finished (one clock) |
| req_err | output | 1 | Address matched no window |
| req_rdata | output | 16 | Read data, valid with req_ack |
| ext_addr | output | 24 | External address |
| ext_cs_n | output | 4 | Chip-selects, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_be_n | output | 2 | Byte-lane enables, active low |
| ext_dout | output | 16 | Write data to the bus |
| ext_doe | output | 1 | Data output enable |
| ext_din | input | 16 | Read data from the bus |
| ext_rdy | input | 1 | External ready; low extends the access |

## Verification
The assertions assume the requester holds its request and request fields steady until the acknowledge. They also assume window registers are not rewritten while an access is in flight, and that ready is a clean level that is only meaningful while a strobe is low. The bench drives every input on the falling clock edge. It issues a request only after the previous acknowledge has been seen, and it loads window registers only between requests. Ready is pulled low only for a bounded number of strobe clocks per request, so every access finishes.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    // Access sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT,
        ST_LAST,
        ST_DONE
    } ebc_state_e;

    // Window granularity: 64 KB
    localparam int GRAN_BITS = 16;

endpackage

// File: rtl/ebc_cfg_regs.sv
module ebc_cfg_regs #(
    parameter int AREAS  = 4,
    parameter int SEL_W  = 8,
    parameter int WAIT_W = 4,
    parameter int IDX_W  = 2,
    parameter int CFG_W  = 22
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_sel,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output logic [AREAS-1:0]              area_en,
    output logic [AREAS-1:0][SEL_W-1:0]   area_base,
    output logic [AREAS-1:0][SEL_W-1:0]   area_mask,
    output logic [AREAS-1:0]              area_wide,
    output logic [AREAS-1:0][WAIT_W-1:0]  area_wait
);
    localparam int MASK_LO = SEL_W;
    localparam int WIDE_B  = 2 * SEL_W;
    localparam int WAIT_LO = WIDE_B + 1;
    localparam int EN_B    = WAIT_LO + WAIT_W;

    for (genvar i = 0; i < AREAS; i++) begin : g_area
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                area_en[i]   <= 1'b0;
                area_base[i] <= '0;
                area_mask[i] <= '0;
                area_wide[i] <= 1'b0;
                area_wait[i] <= '0;
            end else if (cfg_we && (cfg_sel == IDX_W'(i))) begin
                area_base[i] <= cfg_wdata[MASK_LO-1:0];
                area_mask[i] <= cfg_wdata[WIDE_B-1:MASK_LO];
                area_wide[i] <= cfg_wdata[WIDE_B];
                area_wait[i] <= cfg_wdata[EN_B-1:WAIT_LO];
                area_en[i]   <= cfg_wdata[EN_B];
            end
        end
    end

endmodule

// File: rtl/ebc_decode.sv
module ebc_decode #(
    parameter int AREAS = 4,
    parameter int SEL_W = 8,
    parameter int IDX_W = 2
) (
    input  logic [SEL_W-1:0]             addr_hi,
    input  logic [AREAS-1:0]             area_en,
    input  logic [AREAS-1:0][SEL_W-1:0]  area_base,
    input  logic [AREAS-1:0][SEL_W-1:0]  area_mask,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);
    logic [AREAS-1:0] match;

    for (genvar i = 0; i < AREAS; i++) begin : g_match
        assign match[i] = area_en[i] &&
                          (((addr_hi ^ area_base[i]) & area_mask[i]) == '0);
    end

    // Lowest index has priority: scan downward so the last hit wins
    always_comb begin
        hit_idx = '0;
        for (int i = AREAS - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int AREAS  = 4,
    parameter int AW     = 24,
    parameter int WAIT_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_size16,
    input  logic [AW-1:0]     req_addr,
    input  logic [15:0]       req_wdata,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic              hit_wide,
    input  logic [WAIT_W-1:0] hit_wait,
    output logic              req_ack,
    output logic              req_err,
    output logic [15:0]       req_rdata,
    output logic [AW-1:0]     ext_addr,
    output logic [AREAS-1:0]  ext_cs_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic [1:0]        ext_be_n,
    output logic [15:0]       ext_dout,
    output logic              ext_doe,
    input  logic [15:0]       ext_din,
    input  logic              ext_rdy
);
    ebc_state_e        state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;

    logic [AW-1:0]     addr_q;
    logic [15:0]       wdat_q;
    logic [15:0]       rdata_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WAIT_W-1:0] wait_q;
    logic              write_q, size16_q, wide_q, err_q, phase_q;

    logic              accept, split, last_done;
    logic              active_d, strobe_d;
    logic [IDX_W-1:0]  idx_n;
    logic              write_n, err_n;

    logic [AREAS-1:0]  cs_n_q;
    logic              rd_n_q, wr_n_q, ack_q, err_o_q;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign split     = size16_q && !wide_q;
    assign last_done = (state_q == ST_LAST) && ext_rdy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = hit ? ST_SETUP : ST_DONE;
            end
            ST_SETUP: begin
                cnt_d   = wait_q;
                state_d = (wait_q != '0) ? ST_WAIT : ST_LAST;
            end
            ST_WAIT: begin
                cnt_d = cnt_q - WAIT_W'(1);
                if (cnt_q == WAIT_W'(1)) state_d = ST_LAST;
            end
            ST_LAST: begin
                if (ext_rdy) state_d = (split && !phase_q) ? ST_SETUP : ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture, byte phase and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdat_q   <= '0;
            rdata_q  <= '0;
            idx_q    <= '0;
            wait_q   <= '0;
            write_q  <= 1'b0;
            size16_q <= 1'b0;
            wide_q   <= 1'b0;
            err_q    <= 1'b0;
            phase_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q   <= req_addr;
                wdat_q   <= req_wdata;
                idx_q    <= hit_idx;
                wait_q   <= hit_wait;
                write_q  <= req_write;
                size16_q <= req_size16;
                wide_q   <= hit_wide;
                err_q    <= !hit;
                phase_q  <= 1'b0;
                rdata_q  <= '0;
            end
            if (last_done) begin
                if (split) begin
                    if (phase_q) rdata_q[15:8] <= ext_din[7:0];
                    else         rdata_q[7:0]  <= ext_din[7:0];
                    phase_q <= 1'b1;
                end else if (wide_q && size16_q) begin
                    rdata_q <= ext_din;
                end else if (wide_q) begin
                    rdata_q <= {8'h00, addr_q[0] ? ext_din[15:8] : ext_din[7:0]};
                end else begin
                    rdata_q <= {8'h00, ext_din[7:0]};
                end
            end
        end
    end

    // Values the registered outputs take in the next state
    assign idx_n    = accept ? hit_idx : idx_q;
    assign write_n  = accept ? req_write : write_q;
    assign err_n    = accept ? !hit : err_q;
    assign active_d = (state_d == ST_SETUP) || (state_d == ST_WAIT) || (state_d == ST_LAST);
    assign strobe_d = (state_d == ST_WAIT) || (state_d == ST_LAST);

    // Registered control outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q  <= '1;
            rd_n_q  <= 1'b1;
            wr_n_q  <= 1'b1;
            ack_q   <= 1'b0;
            err_o_q <= 1'b0;
        end else begin
            for (int i = 0; i < AREAS; i++) begin
                cs_n_q[i] <= !(active_d && (idx_n == IDX_W'(i)));
            end
            rd_n_q  <= !(strobe_d && !write_n);
            wr_n_q  <= !(strobe_d && write_n);
            ack_q   <= (state_d == ST_DONE);
            err_o_q <= (state_d == ST_DONE) && err_n;
        end
    end

    // Address, lanes and data, all from captured registers
    always_comb begin
        ext_addr = split ? {addr_q[AW-1:1], phase_q} : addr_q;
        if (wide_q && size16_q) begin
            ext_be_n = 2'b00;
            ext_dout = wdat_q;
        end else if (wide_q) begin
            ext_be_n = addr_q[0] ? 2'b01 : 2'b10;
            ext_dout = {wdat_q[7:0], wdat_q[7:0]};
        end else begin
            ext_be_n = 2'b10;
            ext_dout = {8'h00, (split && phase_q) ? wdat_q[15:8] : wdat_q[7:0]};
        end
    end

    assign ext_doe   = write_q && (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign ext_cs_n  = cs_n_q;
    assign ext_rd_n  = rd_n_q;
    assign ext_wr_n  = wr_n_q;
    assign req_ack   = ack_q;
    assign req_err   = err_o_q;
    assign req_rdata = rdata_q;

endmodule

// File: rtl/ebc_top.sv
module ebc_top
    import ebc_pkg::*;
#(
    parameter int AREAS  = 4,
    parameter int AW     = 24,
    parameter int WAIT_W = 4,
    localparam int IDX_W = (AREAS > 1) ? $clog2(AREAS) : 1,
    localparam int SEL_W = AW - GRAN_BITS,
    localparam int CFG_W = 2 * SEL_W + WAIT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_size16,
    input  logic [AW-1:0]     req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_ack,
    output logic              req_err,
    output logic [15:0]       req_rdata,
    output logic [AW-1:0]     ext_addr,
    output logic [AREAS-1:0]  ext_cs_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic [1:0]        ext_be_n,
    output logic [15:0]       ext_dout,
    output logic              ext_doe,
    input  logic [15:0]       ext_din,
    input  logic              ext_rdy
);
    logic [AREAS-1:0]              area_en;
    logic [AREAS-1:0][SEL_W-1:0]   area_base;
    logic [AREAS-1:0][SEL_W-1:0]   area_mask;
    logic [AREAS-1:0]              area_wide;
    logic [AREAS-1:0][WAIT_W-1:0]  area_wait;
    logic                          hit;
    logic [IDX_W-1:0]              hit_idx;

    ebc_cfg_regs #(
        .AREAS(AREAS), .SEL_W(SEL_W), .WAIT_W(WAIT_W), .IDX_W(IDX_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .area_en(area_en), .area_base(area_base), .area_mask(area_mask),
        .area_wide(area_wide), .area_wait(area_wait)
    );

    ebc_decode #(
        .AREAS(AREAS), .SEL_W(SEL_W), .IDX_W(IDX_W)
    ) u_dec (
        .addr_hi(req_addr[AW-1:GRAN_BITS]),
        .area_en(area_en), .area_base(area_base), .area_mask(area_mask),
        .hit(hit), .hit_idx(hit_idx)
    );

    ebc_seq #(
        .AREAS(AREAS), .AW(AW), .WAIT_W(WAIT_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size16(req_size16),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .hit(hit), .hit_idx(hit_idx),
        .hit_wide(area_wide[hit_idx]), .hit_wait(area_wait[hit_idx]),
        .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_be_n(ext_be_n), .ext_dout(ext_dout),
        .ext_doe(ext_doe), .ext_din(ext_din), .ext_rdy(ext_rdy)
    );

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
    parameter int AREAS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AREAS-1:0] ext_cs_n,
    input logic             ext_rd_n,
    input logic             ext_wr_n,
    input logic [15:0]      ext_dout,
    input logic             ext_doe,
    input logic             ext_rdy,
    input logic             req_ack,
    input logic             req_err
);
    logic strobe;
    assign strobe = !ext_rd_n || !ext_wr_n;

    assert_one_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    assert_strobe_in_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !(&ext_cs_n));

    assert_no_rd_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    assert_setup_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&ext_cs_n) && !(&ext_cs_n)) |-> (ext_rd_n && ext_wr_n));

    assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !ext_rdy) |=> (strobe && $stable(ext_cs_n)));

    assert_wdata_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_wr_n && $past(!ext_wr_n)) |-> ($stable(ext_dout) && ext_doe));

    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    assert_ack_cs_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (&ext_cs_n));

    assert_err_no_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ack && $past(&ext_cs_n)));

endmodule

bind ebc_top ebc_checker #(.AREAS(AREAS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_rdy(ext_rdy), .req_ack(req_ack), .req_err(req_err)
);

// File: tb/ebc_top_tb.sv
module ebc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [21:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_size16 = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack, req_err;
    logic [15:0] req_rdata;
    logic [23:0] ext_addr;
    logic [3:0]  ext_cs_n;
    logic        ext_rd_n, ext_wr_n, ext_doe;
    logic [1:0]  ext_be_n;
    logic [15:0] ext_dout;
    logic [15:0] ext_din;
    logic        ext_rdy = 1'b1;

    int tests = 0, fails = 0;

    always #10 clk = ~clk;

    ebc_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_size16(req_size16), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_be_n(ext_be_n), .ext_dout(ext_dout),
        .ext_doe(ext_doe), .ext_din(ext_din), .ext_rdy(ext_rdy)
    );

    // Bench copy of the window table
    logic       t_en[4];
    logic [7:0] t_base[4], t_mask[4];
    logic       t_wide[4];
    int         t_wait[4];

    // External memories (one per chip-select) and reference copies
    logic [7:0] mem[4][256];
    logic [7:0] refm[4][256];

    function automatic int cs_index();
        for (int k = 0; k < 4; k++) if (!ext_cs_n[k]) return k;
        return -1;
    endfunction

    always_comb begin
        int k;
        logic [7:0] a;
        k = cs_index();
        a = ext_addr[7:0];
        ext_din = 16'hxxxx;
        if (k >= 0 && !ext_rd_n) begin
            if (t_wide[k]) ext_din = {mem[k][{a[7:1], 1'b1}], mem[k][{a[7:1], 1'b0}]};
            else           ext_din = {8'h00, mem[k][a]};
        end
    end

    // Memory write and ready stall model
    int stall_left = 0;
    always @(negedge clk) begin
        int k;
        logic [7:0] a;
        k = cs_index();
        a = ext_addr[7:0];
        if (k >= 0 && !ext_wr_n) begin
            if (t_wide[k]) begin
                if (!ext_be_n[0]) mem[k][{a[7:1], 1'b0}] = ext_dout[7:0];
                if (!ext_be_n[1]) mem[k][{a[7:1], 1'b1}] = ext_dout[15:8];
            end else begin
                mem[k][a] = ext_dout[7:0];
            end
        end
        if ((!ext_rd_n || !ext_wr_n) && stall_left > 0) begin
            ext_rdy = 1'b0;
            stall_left--;
        end else begin
            ext_rdy = 1'b1;
        end
    end

    // Scoreboard
    typedef struct packed {
        logic        is_read;
        logic [15:0] data;
        logic        err;
        logic [7:0]  cycles;
        logic [3:0]  csmask;
    } exp_t;
    exp_t  expq[$];
    string tagq[$];

    task automatic check(input string tag, input logic ok, input int act, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp_v);
        end
    endtask

    int         cs_cnt = 0;
    logic [3:0] cs_seen = '0;
    logic       setup_bad = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!(&ext_cs_n)) begin
                if (cs_cnt == 0 && (!ext_rd_n || !ext_wr_n)) setup_bad = 1'b1;
                cs_cnt++;
                cs_seen |= ~ext_cs_n;
            end
            if (req_ack) begin
                if (expq.size() == 0) begin
                    check("R11 unexpected ack", 1'b0, 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check({t, " err"}, req_err == e.err, int'(req_err), int'(e.err));
                    if (e.is_read && !e.err)
                        check({t, " data"}, req_rdata == e.data, int'(req_rdata), int'(e.data));
                    check({t, " cs cycles"}, cs_cnt == int'(e.cycles), cs_cnt, int'(e.cycles));
                    check({t, " cs line"}, cs_seen == e.csmask, int'(cs_seen), int'(e.csmask));
                    check({t, " R4 setup clock"}, !setup_bad, int'(setup_bad), 0);
                end
                cs_cnt = 0;
                cs_seen = '0;
                setup_bad = 1'b0;
            end
        end
    end

    function automatic int exp_area(input logic [23:0] a);
        for (int i = 0; i < 4; i++)
            if (t_en[i] && (((a[23:16] ^ t_base[i]) & t_mask[i]) == 8'h00)) return i;
        return -1;
    endfunction

    task automatic cfg_write(input int sel, input logic en, input logic [7:0] base,
                             input logic [7:0] mask, input logic wide, input int waits);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 2'(sel);
        cfg_wdata = {en, 4'(waits), wide, mask, base};
        t_en[sel] = en; t_base[sel] = base; t_mask[sel] = mask;
        t_wide[sel] = wide; t_wait[sel] = waits;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input string tag, input logic wr, input logic s16,
                          input logic [23:0] a, input logic [15:0] wd, input int stall);
        exp_t e;
        int   k, w, extra;
        logic [7:0] lo, hi;
        k = exp_area(a);
        e = '0;
        e.is_read = !wr;
        lo = {a[7:1], 1'b0};
        hi = {a[7:1], 1'b1};
        if (k < 0) begin
            e.err = 1'b1;
        end else begin
            w = t_wait[k];
            extra = (stall > w) ? stall - w : 0;
            e.cycles = 8'(((s16 && !t_wide[k]) ? 2 * (2 + w) : 2 + w) + extra);
            e.csmask = 4'(1 << k);
            if (wr) begin
                if (s16) begin refm[k][lo] = wd[7:0]; refm[k][hi] = wd[15:8]; end
                else refm[k][a[7:0]] = wd[7:0];
            end else begin
                e.data = s16 ? {refm[k][hi], refm[k][lo]} : {8'h00, refm[k][a[7:0]]};
            end
        end
        expq.push_back(e);
        tagq.push_back(tag);
        @(negedge clk);
        stall_left = stall;
        req_valid = 1'b1; req_write = wr; req_size16 = s16;
        req_addr = a; req_wdata = wd;
        do @(negedge clk); while (!req_ack);
        req_valid = 1'b0;
    endtask

    // Watchdog
    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            t_en[k] = 1'b0; t_base[k] = '0; t_mask[k] = '0; t_wide[k] = 1'b0; t_wait[k] = 0;
            for (int i = 0; i < 256; i++) begin
                mem[k][i]  = 8'(i ^ (k * 37));
                refm[k][i] = 8'(i ^ (k * 37));
            end
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cs idle", ext_cs_n == 4'hF, int'(ext_cs_n), 15);
        check("R1 strobes idle", ext_rd_n && ext_wr_n, int'({ext_rd_n, ext_wr_n}), 3);
        check("R1 ack low", !req_ack, int'(req_ack), 0);
        rst_n = 1'b1;
        do_req("R1 R3 no window after reset", 1'b0, 1'b1, 24'h100004, 16'h0, 0);

        // R12: load windows
        cfg_write(0, 1'b1, 8'h10, 8'hFF, 1'b1, 0);
        cfg_write(1, 1'b1, 8'h20, 8'hF0, 1'b0, 2);
        cfg_write(2, 1'b1, 8'h20, 8'hFF, 1'b1, 1);
        cfg_write(3, 1'b1, 8'h40, 8'hFF, 1'b1, 3);

        do_req("R4 R7 write16 wide",      1'b1, 1'b1, 24'h100010, 16'hBEEF, 0);
        do_req("R4 R7 read16 wide",       1'b0, 1'b1, 24'h100010, 16'h0, 0);
        do_req("R7 write byte odd",       1'b1, 1'b0, 24'h100013, 16'h005A, 0);
        do_req("R7 read byte odd",        1'b0, 1'b0, 24'h100013, 16'h0, 0);
        do_req("R7 read byte even",       1'b0, 1'b0, 24'h100012, 16'h0, 0);
        do_req("R6 read16 ready stall",   1'b0, 1'b1, 24'h100010, 16'h0, 3);
        do_req("R8 R5 split write",       1'b1, 1'b1, 24'h2A0020, 16'h1234, 0);
        do_req("R8 R5 split read",        1'b0, 1'b1, 24'h2A0020, 16'h0, 0);
        do_req("R2 priority low index",   1'b0, 1'b0, 24'h200007, 16'h0, 0);
        do_req("R6 R8 stall past waits",  1'b0, 1'b1, 24'h2A0040, 16'h0, 5);
        do_req("R6 stall inside waits",   1'b0, 1'b0, 24'h2A0041, 16'h0, 2);
        do_req("R5 R7 byte write w3",     1'b1, 1'b0, 24'h4000FF, 16'h00C3, 0);
        do_req("R5 R7 read16 w3",         1'b0, 1'b1, 24'h4000FE, 16'h0, 0);
        do_req("R3 unmapped",             1'b0, 1'b1, 24'h500000, 16'h0, 0);
        do_req("R3 unmapped write",       1'b1, 1'b0, 24'hFF0001, 16'h0077, 0);
        do_req("R9 write after error",    1'b1, 1'b1, 24'h400010, 16'hA55A, 1);
        do_req("R9 read back",            1'b0, 1'b1, 24'h400010, 16'h0, 0);

        // R12: disable window 1, window 2 now owns 0x20xxxx
        cfg_write(1, 1'b0, 8'h20, 8'hF0, 1'b0, 2);
        do_req("R12 R2 next window wins", 1'b0, 1'b1, 24'h200008, 16'h0, 0);
        do_req("R12 R3 freed range",      1'b0, 1'b0, 24'h2A0020, 16'h0, 0);

        repeat (4) @(negedge clk);
        check("R11 queue drained", expq.size() == 0, expq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule